// File: doc/BRIEF.md
# IPv4 Forwarding Decision Stage

This block takes one IPv4 header at a time, already split into its fields, and decides what happens to the packet. Each accepted header is checked for a valid checksum, an allowed total length, the plain IPv4 form and a live hop count. The block then searches a small forwarding table to pick an output port. The result is one of three outcomes: the packet is dropped, it is handed to the CPU as an exception, or it is forwarded on a chosen port. A forwarded packet also gets its TTL decremented and its checksum patched to match.

The forwarding table is filled through a single-entry write port. Each entry holds a prefix, a mask, a port vector and a valid bit. The search walks the entries one per cycle, starting at index 0, and stops at the first valid entry whose masked prefix equals the destination address. Software stores the more specific prefixes at lower indices and keeps a mask-zero catch-all entry last, so the first hit is also the longest match. The block takes a new header only when it is idle, and it marks each result with a one-cycle done pulse.

Top module: `ipv4_fwd_decide`

## Requirements
- R1: `hdr_ready` is high only while the block is idle. A header is taken on a clock edge where `hdr_valid` and `hdr_ready` are both high. After that edge `hdr_ready` stays low until the cycle in which `res_done` is high, and `res_done` never stays high for two cycles in a row.
- R2: The checksum test adds ten 16-bit words with ones-complement arithmetic. The words are, in order: {version, IHL, service type}, total length, identification, {flags, fragment offset}, {TTL, protocol}, checksum, source high, source low, destination high, destination low. If the sum is not 0xFFFF, the packet is dropped.
- R3: A packet whose total length is below 64 or above 1500 is dropped.
- R4: A packet whose version is not 4, or whose IHL is not 5 (options present), goes to the CPU.
- R5: A packet whose TTL is 0 or 1 goes to the CPU.
- R6: Drop takes priority over the CPU exception, and the two flags are never high together. `res_port` is 0 whenever drop or the CPU exception is set.
- R7: A table write stores prefix, mask, port and valid at the written index. Reset clears every valid bit.
- R8: The search checks indices in ascending order and returns the port of the first valid entry that satisfies (dst AND mask) == prefix. An entry whose valid bit is clear never matches.
- R9: If the first hit is at index k, `res_done` goes high k+1 cycles after the accepting edge. A packet already marked for drop or CPU finishes 1 cycle after that edge.
- R10: If no valid entry matches, the packet is dropped, and the result comes N_ENTRIES cycles after the accepting edge.
- R11: A forwarded packet reports TTL−1, and its checksum plus 0x0100 with the end-around carry folded back in. Dropped and CPU packets report their TTL and checksum unchanged.
- R12: The result outputs keep their values from one `res_done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Header fields are valid |
| hdr_ready | output | 1 | Block is idle and can take a header |
| hdr_ver | input | 4 | Version |
| hdr_ihl | input | 4 | Header length in 32-bit words |
| hdr_tos | input | 8 | Service type |
| hdr_len | input | 16 | Total length in bytes |
| hdr_id | input | 16 | Identification |
| hdr_flags | input | 3 | Flags |
| hdr_frag | input | 13 | Fragment offset |
| hdr_ttl | input | 8 | Time to live |
| hdr_proto | input | 8 | Protocol |
| hdr_csum | input | 16 | Header checksum |
| hdr_src | input | 32 | Source address |
| hdr_dst | input | 32 | Destination address |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_prefix | input | 32 | Prefix value |
| tbl_wr_mask | input | 32 | Prefix mask |
| tbl_wr_port | input | PORT_W | Output port vector |
| tbl_wr_valid | input | 1 | Entry valid bit |
| res_done | output | 1 | One-cycle result strobe |
| res_drop | output | 1 | Packet dropped |
| res_cpu | output | 1 | Packet sent to the CPU |
| res_port | output | PORT_W | Chosen output port |
| res_ttl | output | 8 | Outgoing TTL |
| res_csum | output | 16 | Outgoing checksum |

## Verification
The case that is hardest to reach is the end-around carry in the checksum patch, because the input checksum must be consistent with the rest of the header and also have an upper byte of 0xFF. The bench steps the identification field through 256 values and recomputes a correct checksum for each one, so some of these headers land in that range and exercise the wrap. Two other cases need the table in a particular state first: the full-length miss, where the catch-all entry has been removed, and the hit at a late index, where a host entry sits below the default. The bench rewrites the table to set up each of these before sending the matching traffic.

// File: rtl/ipv4_fwd_pkg.sv
package ipv4_fwd_pkg;

   localparam int HDR_BITS  = 160;
   localparam int HDR_WORDS = HDR_BITS / 16;

   typedef struct packed {
      logic [3:0]  ver;
      logic [3:0]  ihl;
      logic [7:0]  tos;
      logic [15:0] len;
      logic [15:0] id;
      logic [2:0]  flags;
      logic [12:0] frag;
      logic [7:0]  ttl;
      logic [7:0]  proto;
      logic [15:0] csum;
      logic [31:0] src;
      logic [31:0] dst;
   } ip_hdr_t;

   typedef enum logic {
      WALK_IDLE   = 1'b0,
      WALK_SEARCH = 1'b1
   } walk_state_t;

   // fold a wide sum into 16 bits with end-around carries
   function automatic logic [15:0] fold16(input logic [19:0] s);
      logic [16:0] f1;
      logic [16:0] f2;
      f1 = {1'b0, s[15:0]} + {13'd0, s[19:16]};
      f2 = {1'b0, f1[15:0]} + {16'd0, f1[16]};
      return f2[15:0];
   endfunction

endpackage

// File: rtl/ip_hdr_check.sv
module ip_hdr_check
   import ipv4_fwd_pkg::*;
#(
   parameter int MIN_LEN = 64,
   parameter int MAX_LEN = 1500
) (
   input  ip_hdr_t     hdr,
   output logic        bad_hdr,
   output logic        to_cpu,
   output logic [15:0] patched_csum
);

   localparam logic [15:0] LEN_LO = 16'(MIN_LEN);
   localparam logic [15:0] LEN_HI = 16'(MAX_LEN);

   logic [HDR_BITS-1:0] flat;
   logic [19:0]         acc [HDR_WORDS+1];
   logic [15:0]         folded;
   logic                csum_ok;
   logic                len_ok;
   logic [16:0]         bumped;

   assign flat   = hdr;
   assign acc[0] = 20'd0;

   generate
      for (genvar w = 0; w < HDR_WORDS; w++) begin : g_word
         assign acc[w+1] = acc[w] + {4'd0, flat[HDR_BITS-1-16*w -: 16]};
      end
   endgenerate

   assign folded  = fold16(acc[HDR_WORDS]);
   assign csum_ok = (folded == 16'hFFFF);
   assign len_ok  = (hdr.len >= LEN_LO) && (hdr.len <= LEN_HI);

   assign bad_hdr = !csum_ok || !len_ok;
   assign to_cpu  = (hdr.ver != 4'd4) || (hdr.ihl != 4'd5) || (hdr.ttl <= 8'd1);

   // TTL word drops by 0x0100, so the complement grows by 0x0100
   assign bumped       = {1'b0, hdr.csum} + 17'h00100;
   assign patched_csum = bumped[15:0] + {15'd0, bumped[16]};

endmodule

// File: rtl/lpm_table.sv
module lpm_table #(
   parameter int N_ENTRIES = 16,
   parameter int PORT_W    = 4,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [31:0]       wr_prefix,
   input  logic [31:0]       wr_mask,
   input  logic [PORT_W-1:0] wr_port,
   input  logic              wr_valid,
   input  logic [31:0]       key,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_hit,
   output logic [PORT_W-1:0] rd_port
);

   logic [31:0]       pfx  [N_ENTRIES];
   logic [31:0]       msk  [N_ENTRIES];
   logic [PORT_W-1:0] prt  [N_ENTRIES];
   logic [N_ENTRIES-1:0] vld;
   logic [N_ENTRIES-1:0] hit_vec;

   generate
      for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pfx[e] <= '0;
               msk[e] <= '0;
               prt[e] <= '0;
               vld[e] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
               pfx[e] <= wr_prefix;
               msk[e] <= wr_mask;
               prt[e] <= wr_port;
               vld[e] <= wr_valid;
            end
         end
         assign hit_vec[e] = vld[e] && ((key & msk[e]) == pfx[e]);
      end
   endgenerate

   assign rd_hit  = hit_vec[rd_idx];
   assign rd_port = prt[rd_idx];

endmodule

// File: rtl/lpm_walker.sv
module lpm_walker
   import ipv4_fwd_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int PORT_W    = 4,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              bad_hdr,
   input  logic              to_cpu,
   input  logic              hit,
   input  logic [PORT_W-1:0] hit_port,
   input  logic [7:0]        ttl_in,
   input  logic [15:0]       csum_in,
   input  logic [15:0]       csum_patched,
   output logic              idle,
   output logic [IDX_W-1:0]  idx,
   output logic              done,
   output logic              drop,
   output logic              cpu,
   output logic [PORT_W-1:0] port,
   output logic [7:0]        ttl_out,
   output logic [15:0]       csum_out
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

   walk_state_t state;

   assign idle = (state == WALK_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= WALK_IDLE;
         idx      <= '0;
         done     <= 1'b0;
         drop     <= 1'b0;
         cpu      <= 1'b0;
         port     <= '0;
         ttl_out  <= '0;
         csum_out <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            WALK_IDLE: begin
               if (start) begin
                  state <= WALK_SEARCH;
                  idx   <= '0;
               end
            end
            WALK_SEARCH: begin
               if (bad_hdr || to_cpu || hit || idx == LAST_IDX) begin
                  state    <= WALK_IDLE;
                  done     <= 1'b1;
                  drop     <= bad_hdr || (!to_cpu && !hit);
                  cpu      <= !bad_hdr && to_cpu;
                  port     <= (!bad_hdr && !to_cpu && hit) ? hit_port : '0;
                  ttl_out  <= (!bad_hdr && !to_cpu && hit) ? ttl_in - 8'd1 : ttl_in;
                  csum_out <= (!bad_hdr && !to_cpu && hit) ? csum_patched : csum_in;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= WALK_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ipv4_fwd_decide.sv
module ipv4_fwd_decide
   import ipv4_fwd_pkg::*;
#(
   parameter int N_ENTRIES = 16,
   parameter int PORT_W    = 4,
   parameter int MIN_LEN   = 64,
   parameter int MAX_LEN   = 1500,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   output logic              hdr_ready,
   input  logic [3:0]        hdr_ver,
   input  logic [3:0]        hdr_ihl,
   input  logic [7:0]        hdr_tos,
   input  logic [15:0]       hdr_len,
   input  logic [15:0]       hdr_id,
   input  logic [2:0]        hdr_flags,
   input  logic [12:0]       hdr_frag,
   input  logic [7:0]        hdr_ttl,
   input  logic [7:0]        hdr_proto,
   input  logic [15:0]       hdr_csum,
   input  logic [31:0]       hdr_src,
   input  logic [31:0]       hdr_dst,
   input  logic              tbl_wr_en,
   input  logic [IDX_W-1:0]  tbl_wr_idx,
   input  logic [31:0]       tbl_wr_prefix,
   input  logic [31:0]       tbl_wr_mask,
   input  logic [PORT_W-1:0] tbl_wr_port,
   input  logic              tbl_wr_valid,
   output logic              res_done,
   output logic              res_drop,
   output logic              res_cpu,
   output logic [PORT_W-1:0] res_port,
   output logic [7:0]        res_ttl,
   output logic [15:0]       res_csum
);

   initial begin
      assert (N_ENTRIES >= 2 && (1 << IDX_W) >= N_ENTRIES)
         else $fatal(1, "N_ENTRIES must be at least 2");
      assert (PORT_W >= 1) else $fatal(1, "PORT_W must be at least 1");
      assert (MIN_LEN >= 20 && MIN_LEN <= MAX_LEN && MAX_LEN < 65536)
         else $fatal(1, "length window out of range");
   end

   ip_hdr_t           hdr_q;
   logic              accept;
   logic              bad_hdr;
   logic              to_cpu;
   logic [15:0]       patched;
   logic [IDX_W-1:0]  walk_idx;
   logic              tbl_hit;
   logic [PORT_W-1:0] tbl_port;
   logic              walk_idle;

   assign hdr_ready = walk_idle;
   assign accept    = hdr_valid && walk_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
      end else if (accept) begin
         hdr_q <= '{ver: hdr_ver, ihl: hdr_ihl, tos: hdr_tos, len: hdr_len,
                    id: hdr_id, flags: hdr_flags, frag: hdr_frag, ttl: hdr_ttl,
                    proto: hdr_proto, csum: hdr_csum, src: hdr_src, dst: hdr_dst};
      end
   end

   ip_hdr_check #(
      .MIN_LEN (MIN_LEN),
      .MAX_LEN (MAX_LEN)
   ) u_check (
      .hdr          (hdr_q),
      .bad_hdr      (bad_hdr),
      .to_cpu       (to_cpu),
      .patched_csum (patched)
   );

   lpm_table #(
      .N_ENTRIES (N_ENTRIES),
      .PORT_W    (PORT_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tbl_wr_en),
      .wr_idx    (tbl_wr_idx),
      .wr_prefix (tbl_wr_prefix),
      .wr_mask   (tbl_wr_mask),
      .wr_port   (tbl_wr_port),
      .wr_valid  (tbl_wr_valid),
      .key       (hdr_q.dst),
      .rd_idx    (walk_idx),
      .rd_hit    (tbl_hit),
      .rd_port   (tbl_port)
   );

   lpm_walker #(
      .N_ENTRIES (N_ENTRIES),
      .PORT_W    (PORT_W)
   ) u_walker (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (accept),
      .bad_hdr      (bad_hdr),
      .to_cpu       (to_cpu),
      .hit          (tbl_hit),
      .hit_port     (tbl_port),
      .ttl_in       (hdr_q.ttl),
      .csum_in      (hdr_q.csum),
      .csum_patched (patched),
      .idle         (walk_idle),
      .idx          (walk_idx),
      .done         (res_done),
      .drop         (res_drop),
      .cpu          (res_cpu),
      .port         (res_port),
      .ttl_out      (res_ttl),
      .csum_out     (res_csum)
   );

endmodule

// File: rtl/ipv4_fwd_decide_chk.sv
module ipv4_fwd_decide_chk #(
   parameter int N_ENTRIES = 16,
   parameter int PORT_W    = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hdr_valid,
   input logic              hdr_ready,
   input logic              res_done,
   input logic              res_drop,
   input logic              res_cpu,
   input logic [PORT_W-1:0] res_port,
   input logic [7:0]        res_ttl,
   input logic [15:0]       res_csum
);

   localparam int CW = $clog2(N_ENTRIES + 2) + 1;

   logic [CW-1:0] since_accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      since_accept <= '0;
      else if (hdr_valid && hdr_ready) since_accept <= CW'(1);
      else if (res_done)               since_accept <= '0;
      else if (since_accept != '0)     since_accept <= since_accept + 1'b1;
   end

   assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid && hdr_ready |=> !hdr_ready);

   assert_ready_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> hdr_ready);

   assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done);

   assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> !(res_drop && res_cpu));

   assert_port_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_done && (res_drop || res_cpu) |-> res_port == '0);

   assert_search_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> since_accept >= CW'(2) && since_accept <= CW'(N_ENTRIES + 1));

   assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !res_done |-> $stable(res_drop) && $stable(res_cpu) && $stable(res_port)
                    && $stable(res_ttl) && $stable(res_csum));

endmodule

bind ipv4_fwd_decide ipv4_fwd_decide_chk #(
   .N_ENTRIES (N_ENTRIES),
   .PORT_W    (PORT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hdr_valid (hdr_valid),
   .hdr_ready (hdr_ready),
   .res_done  (res_done),
   .res_drop  (res_drop),
   .res_cpu   (res_cpu),
   .res_port  (res_port),
   .res_ttl   (res_ttl),
   .res_csum  (res_csum)
);

// File: tb/ipv4_fwd_decide_test.sv
module ipv4_fwd_decide_test;

   localparam int N  = 16;
   localparam int PW = 4;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          hdr_valid = 1'b0;
   logic          hdr_ready;
   logic [3:0]    h_ver = 4'd4, h_ihl = 4'd5;
   logic [7:0]    h_tos = 8'd0, h_ttl = 8'd64, h_proto = 8'd6;
   logic [15:0]   h_len = 16'd100, h_id = 16'h1234, h_csum = 16'd0;
   logic [2:0]    h_flags = 3'd2;
   logic [12:0]   h_frag = 13'd0;
   logic [31:0]   h_src = 32'h0A000001, h_dst = 32'h0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [31:0]   wr_pfx = '0, wr_msk = '0;
   logic [PW-1:0] wr_port = '0;
   logic          wr_vld = 1'b0;
   logic          res_done, res_drop, res_cpu;
   logic [PW-1:0] res_port;
   logic [7:0]    res_ttl;
   logic [15:0]   res_csum;

   ipv4_fwd_decide #(.N_ENTRIES(N), .PORT_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
      .hdr_ver(h_ver), .hdr_ihl(h_ihl), .hdr_tos(h_tos), .hdr_len(h_len),
      .hdr_id(h_id), .hdr_flags(h_flags), .hdr_frag(h_frag), .hdr_ttl(h_ttl),
      .hdr_proto(h_proto), .hdr_csum(h_csum), .hdr_src(h_src), .hdr_dst(h_dst),
      .tbl_wr_en(wr_en), .tbl_wr_idx(wr_idx), .tbl_wr_prefix(wr_pfx),
      .tbl_wr_mask(wr_msk), .tbl_wr_port(wr_port), .tbl_wr_valid(wr_vld),
      .res_done(res_done), .res_drop(res_drop), .res_cpu(res_cpu),
      .res_port(res_port), .res_ttl(res_ttl), .res_csum(res_csum));

   int checks = 0;
   int errors = 0;
   logic finished = 1'b0;

   logic [31:0]   m_pfx [N];
   logic [31:0]   m_msk [N];
   logic [PW-1:0] m_port[N];
   logic          m_vld [N];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ones_sum(input logic [15:0] c);
      logic [31:0] s;
      s = {h_ver, h_ihl, h_tos} + h_len + h_id + {h_flags, h_frag} + {h_ttl, h_proto}
          + c + h_src[31:16] + h_src[15:0] + h_dst[31:16] + h_dst[15:0];
      while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
      return s[15:0];
   endfunction

   task automatic fix_csum();
      h_csum = ~ones_sum(16'd0);
   endtask

   task automatic set_good(input logic [31:0] dst);
      h_ver = 4'd4; h_ihl = 4'd5; h_tos = 8'h10; h_len = 16'd100; h_id = 16'h1234;
      h_flags = 3'd2; h_frag = 13'd0; h_ttl = 8'd64; h_proto = 8'd6;
      h_src = 32'h0A000001; h_dst = dst;
      fix_csum();
   endtask

   task automatic tbl_write(input int idx, input logic [31:0] p, input logic [31:0] m,
                            input logic [PW-1:0] port, input logic v);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_pfx = p; wr_msk = m; wr_port = port; wr_vld = v;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      m_pfx[idx] = p; m_msk[idx] = m; m_port[idx] = port; m_vld[idx] = v;
   endtask

   // drive the current header, wait for the result and compare to the model
   task automatic send(input string req);
      int lat;
      int exp_lat;
      logic e_drop, e_cpu, fwd;
      logic [PW-1:0] e_port;
      logic [16:0] bump;
      logic [15:0] e_csum;
      logic [7:0] e_ttl;
      logic [PW-1:0] held_port;
      @(negedge clk);
      check(hdr_ready === 1'b1, "R1", "ready while idle", 32'(hdr_ready), 32'd1);
      hdr_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      hdr_valid = 1'b0;
      check(hdr_ready === 1'b0, "R1", "ready low while busy", 32'(hdr_ready), 32'd0);
      lat = 0;
      while (lat < 40) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (res_done === 1'b1) break;
      end
      e_drop = (ones_sum(h_csum) != 16'hFFFF) || (h_len < 16'd64) || (h_len > 16'd1500);
      e_cpu  = !e_drop && ((h_ver != 4'd4) || (h_ihl != 4'd5) || (h_ttl <= 8'd1));
      e_port = '0;
      exp_lat = 1;
      fwd = 1'b0;
      if (!e_drop && !e_cpu) begin
         exp_lat = N;
         e_drop = 1'b1;
         for (int i = N - 1; i >= 0; i--) begin
            if (m_vld[i] && ((h_dst & m_msk[i]) == m_pfx[i])) begin
               exp_lat = i + 1; e_drop = 1'b0; e_port = m_port[i];
            end
         end
         fwd = !e_drop;
      end
      bump   = {1'b0, h_csum} + 17'h100;
      e_csum = fwd ? (bump[15:0] + {15'd0, bump[16]}) : h_csum;
      e_ttl  = fwd ? h_ttl - 8'd1 : h_ttl;
      check(res_done === 1'b1 && lat == exp_lat, req, "latency R9", 32'(lat), 32'(exp_lat));
      check(res_drop === e_drop, req, "drop", 32'(res_drop), 32'(e_drop));
      check(res_cpu === e_cpu, req, "cpu R6", 32'(res_cpu), 32'(e_cpu));
      check(res_port === e_port, req, "port", 32'(res_port), 32'(e_port));
      check(res_ttl === e_ttl, req, "ttl R11", 32'(res_ttl), 32'(e_ttl));
      check(res_csum === e_csum, req, "csum R11", 32'(res_csum), 32'(e_csum));
      check(hdr_ready === 1'b1, "R1", "ready at done", 32'(hdr_ready), 32'd1);
      held_port = res_port;
      @(negedge clk);
      check(res_done === 1'b0 && res_port === held_port, "R12", "hold after done",
            32'(res_port), 32'(held_port));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < N; i++) begin
         m_pfx[i] = '0; m_msk[i] = '0; m_port[i] = '0; m_vld[i] = 1'b0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_done === 1'b0 && res_drop === 1'b0 && res_port === '0, "R1",
            "reset outputs", {res_done, res_drop, 26'd0, res_port}, 32'd0);
      check(hdr_ready === 1'b1, "R1", "reset ready", 32'(hdr_ready), 32'd1);

      // R7: empty table after reset, every lookup misses
      set_good(32'h0A010205); send("R7");

      tbl_write(0, 32'h0A010200, 32'hFFFFFF00, 4'b0001, 1'b1);
      tbl_write(1, 32'h0A010000, 32'hFFFF0000, 4'b0010, 1'b1);
      tbl_write(2, 32'h0A000000, 32'hFF000000, 4'b0100, 1'b1);
      tbl_write(3, 32'hC0A80000, 32'hFFFF0000, 4'b0010, 1'b1);
      tbl_write(4, 32'h00000000, 32'h00000000, 4'b0001, 1'b0);
      tbl_write(15, 32'h00000000, 32'h00000000, 4'b1000, 1'b1);

      // R8: longest prefix through ordering, invalid entry 4 skipped
      set_good(32'h0A010205); send("R8");
      set_good(32'h0A01FF01); send("R8");
      set_good(32'h0A010300); send("R8");
      set_good(32'h0A7F0000); send("R8");
      set_good(32'hC0A80101); send("R8");
      set_good(32'h08080808); send("R8");

      // R9: host route placed late but before default
      tbl_write(5, 32'h08080808, 32'hFFFFFFFF, 4'b0001, 1'b1);
      set_good(32'h08080808); send("R9");
      set_good(32'h08080809); send("R9");

      // R5: full TTL sweep
      for (int t = 0; t < 256; t++) begin
         set_good(32'h0A010205); h_ttl = 8'(t); fix_csum(); send("R5");
      end
      // R3: length boundaries
      for (int l = 56; l <= 72; l++) begin
         set_good(32'h0A01FF01); h_len = 16'(l); fix_csum(); send("R3");
      end
      for (int l = 1492; l <= 1508; l++) begin
         set_good(32'h0A7F0000); h_len = 16'(l); fix_csum(); send("R3");
      end
      // R4: version and header length sweeps
      for (int v = 0; v < 16; v++) begin
         set_good(32'hC0A80101); h_ver = 4'(v); fix_csum(); send("R4");
      end
      for (int v = 0; v < 16; v++) begin
         set_good(32'hC0A80101); h_ihl = 4'(v); fix_csum(); send("R4");
      end
      // R2: every single-bit checksum error
      for (int b = 0; b < 16; b++) begin
         set_good(32'h0A010205); h_csum = h_csum ^ (16'd1 << b); send("R2");
      end
      // R6: bad checksum together with CPU conditions
      set_good(32'h0A010205); h_ttl = 8'd1; fix_csum(); h_csum = h_csum ^ 16'h0004; send("R6");
      set_good(32'h0A010205); h_ver = 4'd6; h_len = 16'd20; fix_csum(); send("R6");
      // R11: identification sweep reaches checksums with wrap
      for (int k = 0; k < 256; k++) begin
         set_good(32'h0A01FF01); h_id = {8'(k), 8'(255 - k)}; h_ttl = 8'(2 + k % 200);
         fix_csum(); send("R11");
      end
      // R10: remove the default entry, misses walk the whole table
      tbl_write(15, 32'h00000000, 32'h00000000, 4'b1000, 1'b0);
      set_good(32'h0B000001); send("R10");
      set_good(32'h08080808); send("R10");

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule